// File: doc/BRIEF.md
# Inclusive Two-Level Cache Coherence Controller

This block holds the coherence state of one processor's private first-level and second-level caches. The two levels are kept inclusive and use a three-state MSI protocol. The block takes one processor operation at a time: a read, a write, a forced first-level eviction or a forced second-level eviction. It walks the two tag arrays one step per cycle. It sends notices to the second level, invalidation notices to the first level, and commands to a shared bus. The bus is modelled as a request that is held until a single-cycle done pulse arrives. No data is stored. The block only keeps the per-line states and tags that decide which messages must be sent.

Both arrays are direct mapped and use the low line-address bits as the index. A miss in either level whose set is already occupied first removes the line that lives there. A dirty first-level victim is written into the second level. A clean one is dropped without a message. A second-level victim is first invalidated in the first level, and it is written to the bus if it is dirty. A probe port reports the state of any line in both levels, so that inclusion can be checked from outside.

Top module: `incl_cache_ctl`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_req` is 0, and every line probes as I in both levels. State codes are I=0, S=1, M=2.
- R2: A read (op 0) that misses both levels sends a second-level notice of kind RD (0) and issues bus command BusRd (0) for the line. The line then probes S in both levels.
- R3: A read that hits the first level completes without any second-level notice, bus command or invalidation notice.
- R4: A read that misses the first level but hits the second level sends a notice of kind RD. The first level is filled in S, the second-level state is unchanged, and no bus command is issued.
- R5: A write (op 1) to a line that is I in the first level and M in the second level sends a notice of kind RDX (1). The first level is filled in M and no bus command is issued.
- R6: A write that misses the second level issues BusRdX (1). A write that finds S in the second level issues BusUpgr (2). In both cases the line ends M in both levels.
- R7: A write that hits S in the first level sends a notice of kind UPG (2) to the second level.
- R8: A first-level eviction (op 2) of an M line sends a notice of kind WB (3) and leaves the second-level state unchanged. Eviction of an S line sends no message. In both cases the line becomes I in the first level.
- R9: A second-level eviction, whether forced (op 3) or caused by a conflict miss, sends one invalidation notice for the victim line. If the victim is M, BusWB (3) follows for the victim. The victim ends I in both levels.
- R10: At every cycle, a line that is valid in the first level is valid in the second level, and a line that is M in the first level is M in the second level.
- R11: `req_ready` is low from the cycle after an accepted request until the request completes. While `bus_done` is low, `bus_req`, `bus_cmd` and `bus_addr` stay unchanged.
- R12: A first-level conflict miss with an M victim sends a WB notice for the victim before the notice for the requested line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor operation offered |
| req_op | input | 2 | 0 read, 1 write, 2 first-level evict, 3 second-level evict |
| req_addr | input | ADDR_W | Line address of the operation |
| req_ready | output | 1 | Controller idle and able to accept |
| req_done | output | 1 | One-cycle pulse when the operation completes |
| l2req_valid | output | 1 | Pulse: notice sent to the second level |
| l2req_kind | output | 2 | 0 RD, 1 RDX, 2 UPG, 3 WB |
| l2req_addr | output | ADDR_W | Line of the second-level notice |
| l1inv_valid | output | 1 | Pulse: first-level invalidation notice |
| l1inv_addr | output | ADDR_W | Line to invalidate in the first level |
| bus_req | output | 1 | Bus command pending |
| bus_cmd | output | 2 | 0 BusRd, 1 BusRdX, 2 BusUpgr, 3 BusWB |
| bus_addr | output | ADDR_W | Line of the bus command |
| bus_done | input | 1 | Bus command completes in this cycle |
| probe_addr | input | ADDR_W | Line whose state is reported |
| probe_l1_st | output | 2 | First-level state of the probed line |
| probe_l2_st | output | 2 | Second-level state of the probed line |

## Verification
Two functions can fall on the same line within one request. The first-level writeback of a dirty victim and the second-level eviction of that same dirty line both occur in a read that conflicts in both levels. This is provoked by writing one line so that it is M in both levels, then reading a second line that maps to the same set of each array. The expected result is a WB notice, one invalidation notice, then BusWB and BusRd, in that order, with the old line ending I in both levels. A second overlap occurs when a bus completion fills both arrays on the same edge. It is judged by probing the whole address space for inclusion after every operation.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
   typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} line_st_t;
   typedef enum logic [1:0] {OP_RD = 2'd0, OP_WR = 2'd1, OP_EV1 = 2'd2, OP_EV2 = 2'd3} op_t;
   typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPG = 2'd2, BC_WB = 2'd3} bus_cmd_t;
   typedef enum logic [1:0] {LK_RD = 2'd0, LK_RDX = 2'd1, LK_UPG = 2'd2, LK_WB = 2'd3} l2_kind_t;
   typedef enum logic [2:0] {
      CS_IDLE, CS_L1, CS_L2, CS_EVX, CS_WB, CS_BUS, CS_FIN
   } ctl_st_t;
endpackage

// File: rtl/ilc_tag_array.sv
module ilc_tag_array
   import ilc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SETS   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_addr,
   output line_st_t          look_st,
   output line_st_t          vic_st,
   output logic [ADDR_W-1:0] vic_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   output line_st_t          probe_st,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  line_st_t          wr_st
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - IDX_W;

   initial begin
      assert (SETS >= 2 && (1 << IDX_W) == SETS)
         else $error("tag array: SETS must be a power of two, at least 2");
      assert (TAG_W >= 1)
         else $error("tag array: ADDR_W too small for SETS");
   end

   logic [TAG_W-1:0] tag_q [SETS];
   line_st_t         st_q  [SETS];

   logic [IDX_W-1:0] look_idx, probe_idx, wr_idx;
   assign look_idx  = look_addr[IDX_W-1:0];
   assign probe_idx = probe_addr[IDX_W-1:0];
   assign wr_idx    = wr_addr[IDX_W-1:0];

   for (genvar g = 0; g < SETS; g++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]  <= ST_I;
            tag_q[g] <= '0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            st_q[g]  <= wr_st;
            tag_q[g] <= wr_addr[ADDR_W-1:IDX_W];
         end
      end
   end

   always_comb begin
      vic_st   = st_q[look_idx];
      vic_addr = {tag_q[look_idx], look_idx};
      look_st  = (tag_q[look_idx] == look_addr[ADDR_W-1:IDX_W]) ? st_q[look_idx] : ST_I;
      probe_st = (tag_q[probe_idx] == probe_addr[ADDR_W-1:IDX_W]) ? st_q[probe_idx] : ST_I;
   end
endmodule

// File: rtl/ilc_ctrl.sv
module ilc_ctrl
   import ilc_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  op_t               req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              req_done,
   output logic [ADDR_W-1:0] l1_look_addr,
   input  line_st_t          l1_hit_st,
   input  line_st_t          l1_vic_st,
   input  logic [ADDR_W-1:0] l1_vic_addr,
   output logic              l1_wr_en,
   output logic [ADDR_W-1:0] l1_wr_addr,
   output line_st_t          l1_wr_st,
   output logic [ADDR_W-1:0] l2_look_addr,
   input  line_st_t          l2_hit_st,
   input  line_st_t          l2_vic_st,
   input  logic [ADDR_W-1:0] l2_vic_addr,
   output logic              l2_wr_en,
   output logic [ADDR_W-1:0] l2_wr_addr,
   output line_st_t          l2_wr_st,
   output logic              l2req_valid,
   output l2_kind_t          l2req_kind,
   output logic [ADDR_W-1:0] l2req_addr,
   output logic              l1inv_valid,
   output logic [ADDR_W-1:0] l1inv_addr,
   output logic              bus_req,
   output bus_cmd_t          bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_done
);
   ctl_st_t           cs_q, cs_d;
   op_t               op_q, op_d;
   logic [ADDR_W-1:0] addr_q, addr_d, vic_q, vic_d;
   logic              vic_m_q, vic_m_d, then_bus_q, then_bus_d;
   bus_cmd_t          cmd_q, cmd_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q       <= CS_IDLE;
         op_q       <= OP_RD;
         addr_q     <= '0;
         vic_q      <= '0;
         vic_m_q    <= 1'b0;
         then_bus_q <= 1'b0;
         cmd_q      <= BC_RD;
      end else begin
         cs_q       <= cs_d;
         op_q       <= op_d;
         addr_q     <= addr_d;
         vic_q      <= vic_d;
         vic_m_q    <= vic_m_d;
         then_bus_q <= then_bus_d;
         cmd_q      <= cmd_d;
      end
   end

   assign l1_look_addr = (cs_q == CS_EVX) ? vic_q : addr_q;
   assign l2_look_addr = addr_q;

   always_comb begin
      cs_d = cs_q; op_d = op_q; addr_d = addr_q; vic_d = vic_q;
      vic_m_d = vic_m_q; then_bus_d = then_bus_q; cmd_d = cmd_q;
      req_ready = 1'b0; req_done = 1'b0;
      l1_wr_en = 1'b0; l1_wr_addr = addr_q; l1_wr_st = ST_I;
      l2_wr_en = 1'b0; l2_wr_addr = addr_q; l2_wr_st = ST_I;
      l2req_valid = 1'b0; l2req_kind = LK_RD; l2req_addr = addr_q;
      l1inv_valid = 1'b0; l1inv_addr = vic_q;
      bus_req = 1'b0; bus_cmd = cmd_q; bus_addr = addr_q;
      unique case (cs_q)
         CS_IDLE: begin
            req_ready = 1'b1;
            if (req_valid) begin
               op_d = req_op; addr_d = req_addr; cs_d = CS_L1;
            end
         end
         CS_L1: begin
            if (op_q == OP_EV2) begin
               if (l2_hit_st != ST_I) begin
                  vic_d = addr_q; vic_m_d = (l2_hit_st == ST_M);
                  then_bus_d = 1'b0; cs_d = CS_EVX;
               end else cs_d = CS_FIN;
            end else if (op_q == OP_EV1) begin
               if (l1_hit_st != ST_I) begin
                  l1_wr_en = 1'b1;
                  if (l1_hit_st == ST_M) begin
                     l2req_valid = 1'b1; l2req_kind = LK_WB;
                  end
               end
               cs_d = CS_FIN;
            end else if (l1_hit_st == ST_M || (l1_hit_st == ST_S && op_q == OP_RD)) begin
               cs_d = CS_FIN;
            end else begin
               if (l1_hit_st == ST_I && l1_vic_st != ST_I) begin
                  l1_wr_en = 1'b1; l1_wr_addr = l1_vic_addr;
                  if (l1_vic_st == ST_M) begin
                     l2req_valid = 1'b1; l2req_kind = LK_WB; l2req_addr = l1_vic_addr;
                  end
               end
               cs_d = CS_L2;
            end
         end
         CS_L2: begin
            l2req_valid = 1'b1;
            if (op_q == OP_RD) l2req_kind = LK_RD;
            else l2req_kind = (l1_hit_st == ST_S) ? LK_UPG : LK_RDX;
            if (op_q == OP_RD && l2_hit_st != ST_I) begin
               l1_wr_en = 1'b1; l1_wr_st = ST_S; cs_d = CS_FIN;
            end else if (op_q != OP_RD && l2_hit_st == ST_M) begin
               l1_wr_en = 1'b1; l1_wr_st = ST_M; cs_d = CS_FIN;
            end else if (op_q != OP_RD && l2_hit_st == ST_S) begin
               cmd_d = BC_UPG; cs_d = CS_BUS;
            end else begin
               cmd_d = (op_q == OP_RD) ? BC_RD : BC_RDX;
               if (l2_vic_st != ST_I) begin
                  vic_d = l2_vic_addr; vic_m_d = (l2_vic_st == ST_M);
                  then_bus_d = 1'b1; cs_d = CS_EVX;
               end else cs_d = CS_BUS;
            end
         end
         CS_EVX: begin
            l1inv_valid = 1'b1;
            if (l1_hit_st != ST_I) begin
               l1_wr_en = 1'b1; l1_wr_addr = vic_q;
            end
            if (vic_m_q) cs_d = CS_WB;
            else begin
               l2_wr_en = 1'b1; l2_wr_addr = vic_q;
               cs_d = then_bus_q ? CS_BUS : CS_FIN;
            end
         end
         CS_WB: begin
            bus_req = 1'b1; bus_cmd = BC_WB; bus_addr = vic_q;
            if (bus_done) begin
               l2_wr_en = 1'b1; l2_wr_addr = vic_q;
               cs_d = then_bus_q ? CS_BUS : CS_FIN;
            end
         end
         CS_BUS: begin
            bus_req = 1'b1;
            if (bus_done) begin
               l1_wr_en = 1'b1; l2_wr_en = 1'b1;
               l1_wr_st = (cmd_q == BC_RD) ? ST_S : ST_M;
               l2_wr_st = (cmd_q == BC_RD) ? ST_S : ST_M;
               cs_d = CS_FIN;
            end
         end
         CS_FIN: begin
            req_done = 1'b1; cs_d = CS_IDLE;
         end
         default: cs_d = CS_IDLE;
      endcase
   end

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);                        // R11
   AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_done |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_done |=> req_ready);                                       // R11
   AST_NOTICE_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      l1inv_valid |-> !bus_req);                                     // R9
endmodule

// File: rtl/incl_cache_ctl.sv
module incl_cache_ctl
   import ilc_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int L1_SETS = 4,
   parameter int L2_SETS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              req_done,
   output logic              l2req_valid,
   output logic [1:0]        l2req_kind,
   output logic [ADDR_W-1:0] l2req_addr,
   output logic              l1inv_valid,
   output logic [ADDR_W-1:0] l1inv_addr,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_done,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic [1:0]        probe_l1_st,
   output logic [1:0]        probe_l2_st
);
   initial begin
      assert (L2_SETS >= L1_SETS)
         else $error("second level must have at least as many sets as the first");
   end

   logic [ADDR_W-1:0] l1_look, l1_vic_a, l1_wa, l2_look, l2_vic_a, l2_wa;
   line_st_t          l1_hit, l1_vic, l1_ws, l2_hit, l2_vic, l2_ws, p1, p2;
   logic              l1_we, l2_we;
   l2_kind_t          kind;
   bus_cmd_t          cmd;

   ilc_tag_array #(.ADDR_W(ADDR_W), .SETS(L1_SETS)) u_l1 (
      .clk, .rst_n, .look_addr(l1_look), .look_st(l1_hit), .vic_st(l1_vic),
      .vic_addr(l1_vic_a), .probe_addr, .probe_st(p1),
      .wr_en(l1_we), .wr_addr(l1_wa), .wr_st(l1_ws));

   ilc_tag_array #(.ADDR_W(ADDR_W), .SETS(L2_SETS)) u_l2 (
      .clk, .rst_n, .look_addr(l2_look), .look_st(l2_hit), .vic_st(l2_vic),
      .vic_addr(l2_vic_a), .probe_addr, .probe_st(p2),
      .wr_en(l2_we), .wr_addr(l2_wa), .wr_st(l2_ws));

   ilc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk, .rst_n, .req_valid, .req_op(op_t'(req_op)), .req_addr,
      .req_ready, .req_done,
      .l1_look_addr(l1_look), .l1_hit_st(l1_hit), .l1_vic_st(l1_vic), .l1_vic_addr(l1_vic_a),
      .l1_wr_en(l1_we), .l1_wr_addr(l1_wa), .l1_wr_st(l1_ws),
      .l2_look_addr(l2_look), .l2_hit_st(l2_hit), .l2_vic_st(l2_vic), .l2_vic_addr(l2_vic_a),
      .l2_wr_en(l2_we), .l2_wr_addr(l2_wa), .l2_wr_st(l2_ws),
      .l2req_valid, .l2req_kind(kind), .l2req_addr,
      .l1inv_valid, .l1inv_addr,
      .bus_req, .bus_cmd(cmd), .bus_addr, .bus_done);

   assign l2req_kind  = kind;
   assign bus_cmd     = cmd;
   assign probe_l1_st = p1;
   assign probe_l2_st = p2;

   AST_INCLUSION: assert property (@(posedge clk) disable iff (!rst_n)
      probe_l1_st != 2'd0 |-> probe_l2_st != 2'd0);                 // R10
   AST_DIRTY_INCLUSION: assert property (@(posedge clk) disable iff (!rst_n)
      probe_l1_st == 2'd2 |-> probe_l2_st == 2'd2);                 // R10
endmodule

// File: tb/incl_cache_ctl_tb_top.sv
module incl_cache_ctl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [7:0] req_addr = 8'd0;
   logic       req_ready, req_done, l2req_valid, l1inv_valid, bus_req;
   logic [1:0] l2req_kind, bus_cmd, probe_l1_st, probe_l2_st;
   logic [7:0] l2req_addr, l1inv_addr, bus_addr;
   logic       bus_done = 1'b0;
   logic [7:0] probe_addr = 8'd0;

   always #4 clk = ~clk;

   incl_cache_ctl dut_i (
      .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_ready, .req_done,
      .l2req_valid, .l2req_kind, .l2req_addr, .l1inv_valid, .l1inv_addr,
      .bus_req, .bus_cmd, .bus_addr, .bus_done,
      .probe_addr, .probe_l1_st, .probe_l2_st);

   int n_chk = 0, n_err = 0;
   int st_chk = 0, st_err = 0;
   int l2_n = 0, bus_n = 0, inv_n = 0, done_n = 0;
   logic [1:0] l2_k [64];
   logic [7:0] l2_a [64];
   logic [1:0] bus_k [64];
   logic [7:0] bus_a [64];
   logic [7:0] inv_a [64];
   int  wcnt = 0;
   bit  tracking = 0;
   logic [1:0] t_cmd = 2'd0;
   logic [7:0] t_addr = 8'd0;
   int  b_l2, b_bus, b_inv;

   always @(negedge clk) begin
      if (rst_n) begin
         if (l2req_valid && l2_n < 64) begin l2_k[l2_n] = l2req_kind; l2_a[l2_n] = l2req_addr; l2_n++; end
         if (l1inv_valid && inv_n < 64) begin inv_a[inv_n] = l1inv_addr; inv_n++; end
         if (req_done) done_n++;
         if (bus_done) begin
            bus_done = 1'b0; tracking = 0; wcnt = 0;
         end else if (bus_req) begin
            if (!tracking) begin
               tracking = 1; t_cmd = bus_cmd; t_addr = bus_addr; wcnt = 0;
            end else begin
               st_chk++;
               if (bus_cmd !== t_cmd || bus_addr !== t_addr) begin
                  st_err++;
                  $display("FAIL R11 bus hold: actual=%0h/%0h expected=%0h/%0h", bus_cmd, bus_addr, t_cmd, t_addr);
               end
            end
            wcnt++;
            if (wcnt >= 3 && bus_n < 64) begin
               bus_k[bus_n] = bus_cmd; bus_a[bus_n] = bus_addr; bus_n++; bus_done = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #2;
   endtask

   task automatic probe(input logic [7:0] a, output logic [1:0] s1, output logic [1:0] s2);
      probe_addr = a; #1; s1 = probe_l1_st; s2 = probe_l2_st;
   endtask

   task automatic exp_st(input string req, input logic [7:0] a, input int e1, input int e2);
      logic [1:0] s1, s2;
      probe(a, s1, s2);
      chk(s1 == e1[1:0], req, $sformatf("L1 state of %0h", a), s1, e1);
      chk(s2 == e2[1:0], req, $sformatf("L2 state of %0h", a), s2, e2);
   endtask

   task automatic incl_scan();
      int bad = 0;
      int first = -1;
      for (int a = 0; a < 256; a++) begin
         logic [1:0] s1, s2;
         probe(a[7:0], s1, s2);
         if ((s1 != 0 && s2 == 0) || (s1 == 2 && s2 != 2)) begin
            bad++; if (first < 0) first = a;
         end
      end
      chk(bad == 0, "R10", "inclusion violations (first line)", first, -1);
   endtask

   task automatic run_op(input int op, input logic [7:0] a);
      int guard = 0;
      int d0;
      b_l2 = l2_n; b_bus = bus_n; b_inv = inv_n; d0 = done_n;
      req_op = op[1:0]; req_addr = a; req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
      while (done_n == d0 && guard < 300) begin step(); guard++; end
      chk(done_n == d0 + 1, "R11", "request completed (watchdog)", done_n - d0, 1);
      chk(req_ready == 1'b1, "R11", "ready after done", req_ready, 1);
      incl_scan();
   endtask

   task automatic exp_cnts(input string req, input int nl2, input int nbus, input int ninv);
      chk(l2_n - b_l2 == nl2, req, "L2 notice count", l2_n - b_l2, nl2);
      chk(bus_n - b_bus == nbus, req, "bus command count", bus_n - b_bus, nbus);
      chk(inv_n - b_inv == ninv, req, "invalidation count", inv_n - b_inv, ninv);
   endtask

   task automatic exp_l2(input string req, input int i, input int k, input logic [7:0] a);
      chk(l2_k[b_l2+i] == k[1:0] && l2_a[b_l2+i] == a, req, $sformatf("L2 notice %0d kind/addr", i),
          {l2_k[b_l2+i], l2_a[b_l2+i]}, {k[1:0], a});
   endtask

   task automatic exp_bus(input string req, input int i, input int k, input logic [7:0] a);
      chk(bus_k[b_bus+i] == k[1:0] && bus_a[b_bus+i] == a, req, $sformatf("bus cmd %0d kind/addr", i),
          {bus_k[b_bus+i], bus_a[b_bus+i]}, {k[1:0], a});
   endtask

   task automatic exp_inv(input string req, input int i, input logic [7:0] a);
      chk(inv_a[b_inv+i] == a, req, $sformatf("invalidation %0d addr", i), inv_a[b_inv+i], a);
   endtask

   localparam logic [7:0] LA = 8'h01, LB = 8'h11, LC = 8'h05;

   task automatic t_reset();
      chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
      chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
      exp_st("R1", LA, 0, 0);
      exp_st("R1", 8'hFF, 0, 0);
      incl_scan();
   endtask

   task automatic t_read_miss();
      run_op(0, LA);
      exp_cnts("R2", 1, 1, 0);
      exp_l2("R2", 0, 0, LA);
      exp_bus("R2", 0, 0, LA);
      exp_st("R2", LA, 1, 1);
   endtask

   task automatic t_read_hit();
      run_op(0, LA);
      exp_cnts("R3", 0, 0, 0);
      exp_st("R3", LA, 1, 1);
   endtask

   task automatic t_write_s_hit();
      run_op(1, LA);
      exp_cnts("R7", 1, 1, 0);
      exp_l2("R7", 0, 2, LA);
      exp_bus("R6", 0, 2, LA);
      exp_st("R6", LA, 2, 2);
   endtask

   task automatic t_evict_l1_dirty();
      run_op(2, LA);
      exp_cnts("R8", 1, 0, 0);
      exp_l2("R8", 0, 3, LA);
      exp_st("R8", LA, 0, 2);
   endtask

   task automatic t_write_l2_m();
      run_op(1, LA);
      exp_cnts("R5", 1, 0, 0);
      exp_l2("R5", 0, 1, LA);
      exp_st("R5", LA, 2, 2);
   endtask

   task automatic t_l1_conflict();
      run_op(0, LC);
      exp_cnts("R12", 2, 1, 0);
      exp_l2("R12", 0, 3, LA);
      exp_l2("R12", 1, 0, LC);
      exp_bus("R12", 0, 0, LC);
      exp_st("R12", LA, 0, 2);
      exp_st("R12", LC, 1, 1);
   endtask

   task automatic t_read_l2_hit();
      run_op(0, LA);
      exp_cnts("R4", 1, 0, 0);
      exp_l2("R4", 0, 0, LA);
      exp_st("R4", LA, 1, 2);
      exp_st("R8", LC, 0, 1);
   endtask

   task automatic t_l2_conflict_write();
      run_op(1, LB);
      exp_cnts("R9", 1, 2, 1);
      exp_l2("R6", 0, 1, LB);
      exp_inv("R9", 0, LA);
      exp_bus("R9", 0, 3, LA);
      exp_bus("R6", 1, 1, LB);
      exp_st("R9", LA, 0, 0);
      exp_st("R6", LB, 2, 2);
   endtask

   task automatic t_evict_l2_clean();
      run_op(0, LC);
      exp_cnts("R12", 2, 0, 0);
      exp_l2("R12", 0, 3, LB);
      exp_l2("R4", 1, 0, LC);
      run_op(3, LC);
      exp_cnts("R9", 0, 0, 1);
      exp_inv("R9", 0, LC);
      exp_st("R9", LC, 0, 0);
   endtask

   task automatic t_evict_l2_dirty();
      run_op(3, LB);
      exp_cnts("R9", 0, 1, 1);
      exp_inv("R9", 0, LB);
      exp_bus("R9", 0, 3, LB);
      exp_st("R9", LB, 0, 0);
      run_op(1, LA);
      exp_bus("R6", 0, 1, LA);
      exp_st("R6", LA, 2, 2);
      run_op(3, LA);
      exp_cnts("R9", 0, 1, 1);
      exp_bus("R9", 0, 3, LA);
      exp_st("R9", LA, 0, 0);
   endtask

   task automatic t_evict_l1_clean();
      run_op(0, LC);
      run_op(2, LC);
      exp_cnts("R8", 0, 0, 0);
      exp_st("R8", LC, 0, 1);
      run_op(2, 8'h33);
      exp_cnts("R8", 0, 0, 0);
   endtask

   task automatic t_same_line_both_levels();
      run_op(1, LA);
      run_op(0, LB);
      exp_cnts("R12", 2, 2, 1);
      exp_l2("R12", 0, 3, LA);
      exp_l2("R2", 1, 0, LB);
      exp_inv("R9", 0, LA);
      exp_bus("R9", 0, 3, LA);
      exp_bus("R2", 1, 0, LB);
      exp_st("R9", LA, 0, 0);
      exp_st("R2", LB, 1, 1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_read_miss();
      t_read_hit();
      t_write_s_hit();
      t_evict_l1_dirty();
      t_write_l2_m();
      t_l1_conflict();
      t_read_l2_hit();
      t_l2_conflict_write();
      t_evict_l2_clean();
      t_evict_l2_dirty();
      t_evict_l1_clean();
      t_same_line_both_levels();
      repeat (2) step();
      $display("Result: errors=%0d of %0d checks", n_err + st_err, n_chk + st_chk);
      $finish;
   end

   initial begin
      #1600000;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err + st_err + 1, n_chk + st_chk + 1);
      $finish;
   end
endmodule